// File: doc/BRIEF.md
# Debug System Bus Access Master

This block gives an external debugger a path into system memory without the help of any processor. The debugger sees a small bank of 32-bit registers: one control word, four address words that together form a 128-bit address, and four data words. Bus transfers are never requested directly. They start as a side effect of particular register reads and writes. A write to the lowest address word can fetch from the new address. Reading the lowest data word can move the address forward and fetch again. Writing the lowest data word stores its contents to memory.

Transfers go out on a simple request/response port. The request stays asserted, with a fixed address, size and write data, until the memory returns a one-cycle response that carries read data and an error flag. After each access the address can advance by the access size. The carry ripples through all four address words. Errors stick in a three-bit code until the debugger clears them, and no new transfer starts while an error is pending.

Top module: `sba_master`

## Requirements
- R1: After reset, the control word (select 0) reads as version 1 in bits [31:29], the system address width in bits [20:14], all four size capabilities set in bits [13:10], and every other bit zero. All address and data words read zero, and no bus request is raised.
- R2: Control bits [2:0] hold the size code. Codes 0, 1, 2 and 3 select 1, 2, 4 and 8 byte accesses. A completed read places the result zero-extended into data word 0 (select 8). A code 3 read puts the low 32 bits in data word 0 and the high 32 bits in data word 1 (select 9).
- R3: Writing address word 0 (select 4) with read-on-address (control bit 4) set and error code zero starts a read at the newly written address.
- R4: Reading data word 0 returns its value from before the access. Then, if the error code is zero, the address advances by the access size when autoincrement (bit 3) is set, and a read at the advanced address starts when read-on-data (bit 5) is set.
- R5: Writing data word 0 with error code zero starts a bus write of the new value, with mem_size equal to the size code. A code 3 write sends data word 1 as the upper half. Narrower writes send data word 0 with the bytes above the access size zeroed.
- R6: After a write that completes without error, the address advances by the access size if autoincrement was set when the write started. After a failed write the address is unchanged.
- R7: Address advance is a 128-bit addition across address words 0 to 3 (selects 4 to 7), with the carry rippling from word 0 upward.
- R8: An error response to a read or a write sets the error code (control bits [8:6]) to 2.
- R9: A size code of 4 to 7 on an access that would start a transfer sets the error code to 3, raises no request and leaves the address unchanged.
- R10: While the error code is nonzero, no bus transfer starts.
- R11: A control write updates the mode fields. It clears only those error bits that are written as 1.
- R12: While a transfer is outstanding, control bit 9 reads 1, mem_req stays high and mem_addr stays stable until the response. Writes to address or data words and reads of data word 0 have no effect during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 4 | Register select: 0 control, 4-7 address words, 8-11 data words |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational, value before the access) |
| mem_req | output | 1 | Bus request, held until the response |
| mem_we | output | 1 | Bus write when 1 |
| mem_size | output | 2 | Access size code (0..3) |
| mem_addr | output | 64 | Bus byte address |
| mem_wdata | output | 64 | Bus write data |
| mem_rsp | input | 1 | One-cycle response strobe |
| mem_rerr | input | 1 | Response carries an access error |
| mem_rdata | input | 64 | Response read data |

## Verification
The bench aims at the carry from address word 0 through word 1 into word 2. A stepper that drops the carry leaves word 2 at zero. It checks that reading data word 0 returns the old value before it advances and refetches. A design that fetches first would return new data, or would read the unadvanced address. A register write issued back to back with a read that is still in flight must be dropped, or the address would jump away from the transfer. Byte reads must come back zero-extended. Faults on both reads and writes must stop all further requests. The error bits must clear only where a 1 is written, so a clear with the wrong bit set must leave code 2 in place.

// File: rtl/sba_pkg.sv
package sba_pkg;
   // register selects
   localparam int CTL_SEL   = 0;
   localparam int ADDR_BASE = 4;
   localparam int DATA_BASE = 8;

   // control word bit positions
   localparam int F_INC  = 3;
   localparam int F_ROA  = 4;
   localparam int F_ROD  = 5;
   localparam int F_ERR  = 6;
   localparam int F_BUSY = 9;

   // error codes
   localparam logic [2:0] ERR_NONE  = 3'd0;
   localparam logic [2:0] ERR_FAULT = 3'd2;
   localparam logic [2:0] ERR_SIZE  = 3'd3;

   localparam logic [2:0] SBA_VERSION = 3'd1;
endpackage

// File: rtl/sba_size_decode.sv
module sba_size_decode #(
   parameter int WORD_W = 32,
   parameter int MEM_DW = 64
) (
   input  logic [2:0]        code,
   output logic              code_ok,
   output logic [WORD_W-1:0] step,
   output logic [MEM_DW-1:0] mask
);
   localparam int NBYTES = MEM_DW / 8;

   always_comb begin
      code_ok = (code[2] == 1'b0);
      step    = WORD_W'(1) << code[1:0];
      mask    = '0;
      for (int b = 0; b < NBYTES; b++) begin
         if (b < (1 << code[1:0])) mask[b*8 +: 8] = 8'hFF;
      end
   end
endmodule

// File: rtl/sba_addr_step.sv
module sba_addr_step #(
   parameter int NW = 4,
   parameter int WW = 32
) (
   input  logic [NW*WW-1:0] addr_in,
   input  logic [WW-1:0]    step,
   output logic [NW*WW-1:0] addr_out
);
   logic [NW:0] cy;
   assign cy[0] = 1'b0;

   for (genvar i = 0; i < NW; i++) begin : g_word
      logic [WW-1:0] addend;
      logic [WW:0]   sum;
      if (i == 0) begin : g_lsw
         assign addend = step;
      end else begin : g_up
         assign addend = {{(WW-1){1'b0}}, cy[i]};
      end
      assign sum                 = {1'b0, addr_in[i*WW +: WW]} + {1'b0, addend};
      assign addr_out[i*WW +: WW] = sum[WW-1:0];
      assign cy[i+1]             = sum[WW];
   end
endmodule

// File: rtl/sba_master.sv
module sba_master
   import sba_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int ADDR_WDS  = 4,
   parameter int DATA_WDS  = 4,
   parameter int SYS_AW    = 64,
   parameter int REG_SEL_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_valid,
   input  logic                 reg_write,
   input  logic [REG_SEL_W-1:0] reg_sel,
   input  logic [WORD_W-1:0]    reg_wdata,
   output logic [WORD_W-1:0]    reg_rdata,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [1:0]           mem_size,
   output logic [SYS_AW-1:0]    mem_addr,
   output logic [2*WORD_W-1:0]  mem_wdata,
   input  logic                 mem_rsp,
   input  logic                 mem_rerr,
   input  logic [2*WORD_W-1:0]  mem_rdata
);
   localparam int MEM_DW = 2 * WORD_W;
   localparam int AB     = ADDR_WDS * WORD_W;
   localparam int DB     = DATA_WDS * WORD_W;

   if (WORD_W != 32) begin : g_bad_word
      $error("sba_master: WORD_W must be 32");
   end
   if (DATA_WDS < 2) begin : g_bad_data
      $error("sba_master: need at least two data words");
   end
   if (SYS_AW > AB || SYS_AW > 127) begin : g_bad_aw
      $error("sba_master: SYS_AW exceeds address storage");
   end
   if (DATA_BASE + DATA_WDS > (1 << REG_SEL_W)) begin : g_bad_sel
      $error("sba_master: REG_SEL_W too small");
   end

   logic [2:0]  code_q, err_q, err_d;
   logic        inc_q, roa_q, rod_q, busy_q;
   logic        pend_we_q, pend_inc_q;
   logic [1:0]  pend_code_q;
   logic [AB-1:0] addr_q, addr_d, addr_nxt;
   logic [DB-1:0] data_q, data_d;

   // size decode: pending transfer while busy, else current mode
   logic [2:0]        dec_code;
   logic              sz_ok;
   logic [WORD_W-1:0] sz_step;
   logic [MEM_DW-1:0] sz_mask;

   assign dec_code = busy_q ? {1'b0, pend_code_q} : code_q;

   sba_size_decode #(.WORD_W(WORD_W), .MEM_DW(MEM_DW)) u_dec (
      .code(dec_code), .code_ok(sz_ok), .step(sz_step), .mask(sz_mask)
   );

   sba_addr_step #(.NW(ADDR_WDS), .WW(WORD_W)) u_step (
      .addr_in(addr_q), .step(sz_step), .addr_out(addr_nxt)
   );

   // access decode
   logic acc_wr, acc_rd, idle, no_err;
   logic a0_wr, d0_wr, d0_rd, ctl_wr;
   logic want_rd, want_wr, want, start, start_bad;
   logic bump_rd, bump_wr, rsp, rd_done;

   assign acc_wr  = reg_valid & reg_write;
   assign acc_rd  = reg_valid & ~reg_write;
   assign idle    = ~busy_q;
   assign no_err  = (err_q == ERR_NONE);
   assign ctl_wr  = acc_wr && (reg_sel == REG_SEL_W'(CTL_SEL));
   assign a0_wr   = acc_wr && idle && (reg_sel == REG_SEL_W'(ADDR_BASE));
   assign d0_wr   = acc_wr && idle && (reg_sel == REG_SEL_W'(DATA_BASE));
   assign d0_rd   = acc_rd && idle && (reg_sel == REG_SEL_W'(DATA_BASE));

   assign want_rd   = no_err && ((a0_wr && roa_q) || (d0_rd && rod_q));
   assign want_wr   = no_err && d0_wr;
   assign want      = want_rd | want_wr;
   assign start     = want && sz_ok;
   assign start_bad = want && !sz_ok;
   assign bump_rd   = no_err && d0_rd && inc_q && sz_ok;
   assign rsp       = busy_q && mem_rsp;
   assign bump_wr   = rsp && pend_we_q && pend_inc_q && !mem_rerr;
   assign rd_done   = rsp && !pend_we_q && !mem_rerr;

   always_comb begin
      err_d = err_q;
      if (ctl_wr)    err_d = err_q & ~reg_wdata[F_ERR +: 3];
      if (start_bad) err_d = ERR_SIZE;
      if (rsp && mem_rerr) err_d = ERR_FAULT;
   end

   always_comb begin
      addr_d = addr_q;
      for (int i = 0; i < ADDR_WDS; i++) begin
         if (acc_wr && idle && reg_sel == REG_SEL_W'(ADDR_BASE + i))
            addr_d[i*WORD_W +: WORD_W] = reg_wdata;
      end
      if (bump_rd || bump_wr) addr_d = addr_nxt;
   end

   always_comb begin
      data_d = data_q;
      for (int i = 0; i < DATA_WDS; i++) begin
         if (acc_wr && idle && reg_sel == REG_SEL_W'(DATA_BASE + i))
            data_d[i*WORD_W +: WORD_W] = reg_wdata;
      end
      if (rd_done) begin
         data_d[WORD_W-1:0] = mem_rdata[WORD_W-1:0] & sz_mask[WORD_W-1:0];
         if (pend_code_q == 2'd3)
            data_d[2*WORD_W-1:WORD_W] = mem_rdata[MEM_DW-1:WORD_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q      <= '0;
         inc_q       <= 1'b0;
         roa_q       <= 1'b0;
         rod_q       <= 1'b0;
         err_q       <= ERR_NONE;
         busy_q      <= 1'b0;
         pend_we_q   <= 1'b0;
         pend_inc_q  <= 1'b0;
         pend_code_q <= '0;
         addr_q      <= '0;
         data_q      <= '0;
      end else begin
         if (ctl_wr) begin
            code_q <= reg_wdata[2:0];
            inc_q  <= reg_wdata[F_INC];
            roa_q  <= reg_wdata[F_ROA];
            rod_q  <= reg_wdata[F_ROD];
         end
         err_q  <= err_d;
         addr_q <= addr_d;
         data_q <= data_d;
         if (start) begin
            busy_q      <= 1'b1;
            pend_we_q   <= want_wr;
            pend_inc_q  <= inc_q;
            pend_code_q <= code_q[1:0];
         end else if (rsp) begin
            busy_q <= 1'b0;
         end
      end
   end

   // register read view
   logic [WORD_W-1:0] ctl_view;
   assign ctl_view = {SBA_VERSION, 8'd0, 7'(SYS_AW), 4'b1111, busy_q, err_q,
                      rod_q, roa_q, inc_q, code_q};

   always_comb begin
      reg_rdata = '0;
      if (reg_sel == REG_SEL_W'(CTL_SEL)) reg_rdata = ctl_view;
      for (int i = 0; i < ADDR_WDS; i++)
         if (reg_sel == REG_SEL_W'(ADDR_BASE + i)) reg_rdata = addr_q[i*WORD_W +: WORD_W];
      for (int i = 0; i < DATA_WDS; i++)
         if (reg_sel == REG_SEL_W'(DATA_BASE + i)) reg_rdata = data_q[i*WORD_W +: WORD_W];
   end

   // bus side
   assign mem_req   = busy_q;
   assign mem_we    = pend_we_q;
   assign mem_size  = pend_code_q;
   assign mem_wdata = data_q[MEM_DW-1:0] & sz_mask;

   if (SYS_AW == AB) begin : g_full_addr
      assign mem_addr = addr_q;
   end else begin : g_part_addr
      assign mem_addr = addr_q[SYS_AW-1:0];
   end
endmodule

// File: rtl/sba_master_chk.sv
module sba_master_chk
   import sba_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int SYS_AW    = 64,
   parameter int REG_SEL_W = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_valid,
   input logic                 reg_write,
   input logic [REG_SEL_W-1:0] reg_sel,
   input logic                 mem_req,
   input logic                 mem_rsp,
   input logic                 mem_rerr,
   input logic [SYS_AW-1:0]    mem_addr,
   input logic [2:0]           err_q,
   input logic [WORD_W-1:0]    addr_w0
);
   logic ctl_wr;
   assign ctl_wr = reg_valid && reg_write && (reg_sel == REG_SEL_W'(CTL_SEL));

   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rsp |=> mem_req);

   // R12
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rsp |=> $stable(mem_addr));

   // R12
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rsp && reg_valid && reg_write &&
      reg_sel == REG_SEL_W'(ADDR_BASE) |=> $stable(addr_w0));

   // R8
   fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_rsp && mem_rerr && !ctl_wr |=> err_q == ERR_FAULT);

   // R10
   err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req && err_q != ERR_NONE |=> !mem_req);

   // R12
   rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_rsp |=> !mem_req);
endmodule

bind sba_master sba_master_chk #(
   .WORD_W(WORD_W), .SYS_AW(SYS_AW), .REG_SEL_W(REG_SEL_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
   .reg_sel(reg_sel), .mem_req(mem_req), .mem_rsp(mem_rsp),
   .mem_rerr(mem_rerr), .mem_addr(mem_addr), .err_q(err_q),
   .addr_w0(addr_q[WORD_W-1:0])
);

// File: tb/sba_master_tb.sv
`timescale 1ns/1ps
module sba_master_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0, reg_write = 1'b0;
   logic [3:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [1:0]  mem_size;
   logic [63:0] mem_addr, mem_wdata;
   logic        mem_rsp = 1'b0, mem_rerr = 1'b0;
   logic [63:0] mem_rdata = '0;

   int n_chk = 0, n_err = 0;
   int nreq = 0;
   logic        infl = 1'b0;
   logic [63:0] last_addr = '0, last_wdata = '0;
   logic        last_we = 1'b0;
   logic [1:0]  last_size = '0;

   always #2.5 clk = ~clk;

   sba_master dut_i (.*);

   function automatic logic [63:0] pat(input logic [63:0] a);
      return {~a[31:0], a[31:0] ^ 32'h5A5A_0F0F};
   endfunction

   function automatic logic [31:0] ctlw(input int code, input bit inc, input bit roa,
                                        input bit rod, input int clr);
      return 32'(code) | (32'(inc) << 3) | (32'(roa) << 4) | (32'(rod) << 5) | (32'(clr) << 6);
   endfunction

   // memory model: two-cycle response, fault when address bits [63:60] are 0xE
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rsp <= 1'b0; infl <= 1'b0;
      end else if (mem_rsp) begin
         mem_rsp <= 1'b0; infl <= 1'b0;
      end else if (mem_req) begin
         if (!infl) begin
            infl <= 1'b1; nreq <= nreq + 1;
            last_addr <= mem_addr; last_we <= mem_we;
            last_size <= mem_size; last_wdata <= mem_wdata;
         end else begin
            mem_rsp   <= 1'b1;
            mem_rerr  <= (mem_addr[63:60] == 4'hE);
            mem_rdata <= pat(mem_addr);
         end
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all access tasks start and end at a falling edge
   task automatic reg_wr(input int s, input logic [31:0] d);
      reg_valid = 1'b1; reg_write = 1'b1; reg_sel = 4'(s); reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic reg_rd(input int s, output logic [31:0] d);
      reg_valid = 1'b1; reg_write = 1'b0; reg_sel = 4'(s);
      #1 d = reg_rdata;
      @(negedge clk);
      reg_valid = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int k = 0; k < 40; k++) begin
         reg_rd(0, v);
         if (!v[9]) break;
      end
   endtask

   task automatic err_code(output logic [2:0] e);
      logic [31:0] v;
      reg_rd(0, v);
      e = v[8:6];
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 mem_req", 64'(mem_req), 64'd0);
      reg_rd(0, v); chk("R1 control", 64'(v), 64'h2010_3C00);
      reg_rd(4, v); chk("R1 addr0", 64'(v), 64'd0);
      reg_rd(7, v); chk("R1 addr3", 64'(v), 64'd0);
      reg_rd(8, v); chk("R1 data0", 64'(v), 64'd0);
   endtask

   task automatic t_read_sizes();
      logic [31:0] v, v1;
      logic [63:0] p;
      reg_wr(0, ctlw(2, 0, 1, 0, 0));
      reg_wr(5, 32'h0);
      reg_wr(4, 32'h100); wait_idle();
      chk("R3 addr", last_addr, 64'h100);
      chk("R3 we", 64'(last_we), 64'd0);
      chk("R2 size", 64'(last_size), 64'd2);
      p = pat(64'h100);
      reg_rd(8, v); chk("R2 32-bit data", 64'(v), 64'(p[31:0]));
      reg_wr(0, ctlw(0, 0, 1, 0, 0));
      reg_wr(4, 32'h103); wait_idle();
      p = pat(64'h103);
      reg_rd(8, v); chk("R2 8-bit zero-extend", 64'(v), 64'(p[7:0]));
      reg_wr(0, ctlw(3, 0, 1, 0, 0));
      reg_wr(4, 32'h200); wait_idle();
      p = pat(64'h200);
      reg_rd(8, v); reg_rd(9, v1);
      chk("R2 64-bit low", 64'(v), 64'(p[31:0]));
      chk("R2 64-bit high", 64'(v1), 64'(p[63:32]));
   endtask

   task automatic t_writes();
      logic [31:0] v;
      reg_wr(0, ctlw(1, 1, 0, 0, 0));
      reg_wr(4, 32'h300);
      reg_wr(8, 32'h1234_BEEF); wait_idle();
      chk("R5 16-bit wdata", last_wdata, 64'hBEEF);
      chk("R5 size", 64'(last_size), 64'd1);
      chk("R5 we", 64'(last_we), 64'd1);
      reg_rd(4, v); chk("R6 inc by 2", 64'(v), 64'h302);
      reg_wr(0, ctlw(3, 1, 0, 0, 0));
      reg_wr(4, 32'h310);
      reg_wr(9, 32'h1122_3344);
      reg_wr(8, 32'h5566_7788); wait_idle();
      chk("R5 64-bit wdata", last_wdata, 64'h1122_3344_5566_7788);
      reg_rd(4, v); chk("R6 inc by 8", 64'(v), 64'h318);
   endtask

   task automatic t_carry();
      logic [31:0] v;
      reg_wr(0, ctlw(2, 1, 0, 0, 0));
      reg_wr(6, 32'h0); reg_wr(7, 32'h0);
      reg_wr(5, 32'hFFFF_FFFF);
      reg_wr(4, 32'hFFFF_FFFC);
      reg_wr(8, 32'hAAAA_5555); wait_idle();
      reg_rd(4, v); chk("R7 word0", 64'(v), 64'd0);
      reg_rd(5, v); chk("R7 word1", 64'(v), 64'd0);
      reg_rd(6, v); chk("R7 word2 carry", 64'(v), 64'd1);
      reg_rd(7, v); chk("R7 word3", 64'(v), 64'd0);
      reg_wr(6, 32'h0);
   endtask

   task automatic t_read_on_data();
      logic [31:0] v;
      logic [63:0] p;
      int n0;
      reg_wr(0, ctlw(2, 1, 0, 1, 0));
      reg_wr(4, 32'h400);
      n0 = nreq;
      reg_rd(8, v); chk("R4 old value first", 64'(v), 64'hAAAA_5555);
      wait_idle();
      chk("R4 one read", 64'(nreq - n0), 64'd1);
      chk("R4 read at advanced addr", last_addr, 64'h404);
      p = pat(64'h404);
      reg_wr(0, ctlw(2, 0, 0, 0, 0));
      reg_rd(8, v); chk("R4 fetched data", 64'(v), 64'(p[31:0]));
      reg_rd(4, v); chk("R4 no inc when off", 64'(v), 64'h404);
   endtask

   task automatic t_fault_and_clear();
      logic [2:0] e;
      logic [31:0] v;
      int n0;
      reg_wr(0, ctlw(2, 0, 1, 0, 0));
      reg_wr(5, 32'hE000_0000);
      reg_wr(4, 32'h0); wait_idle();
      err_code(e); chk("R8 read fault code", 64'(e), 64'd2);
      n0 = nreq;
      reg_wr(5, 32'h0);
      reg_wr(8, 32'h0101_0101); wait_idle();
      chk("R10 no write with error", 64'(nreq - n0), 64'd0);
      reg_wr(0, ctlw(1, 1, 0, 1, 1));
      reg_rd(0, v);
      chk("R11 error kept", 64'(v[8:6]), 64'd2);
      chk("R11 modes updated", 64'(v[5:0]), 64'h29);
      reg_wr(0, ctlw(2, 0, 0, 0, 2));
      err_code(e); chk("R11 error cleared", 64'(e), 64'd0);
      // write fault leaves the address alone
      reg_wr(0, ctlw(2, 1, 0, 0, 0));
      reg_wr(5, 32'hE000_0000);
      reg_wr(4, 32'h20);
      reg_wr(8, 32'h7); wait_idle();
      err_code(e); chk("R8 write fault code", 64'(e), 64'd2);
      reg_rd(4, v); chk("R6 no inc after fault", 64'(v), 64'h20);
      reg_wr(0, ctlw(2, 0, 0, 0, 7));
      reg_wr(5, 32'h0);
   endtask

   task automatic t_bad_size();
      logic [2:0] e;
      logic [31:0] v;
      int n0;
      n0 = nreq;
      reg_wr(0, ctlw(5, 1, 1, 0, 0));
      reg_wr(4, 32'h40); wait_idle();
      err_code(e); chk("R9 size error", 64'(e), 64'd3);
      chk("R9 no request", 64'(nreq - n0), 64'd0);
      reg_rd(4, v); chk("R9 addr kept", 64'(v), 64'h40);
      reg_wr(0, ctlw(2, 0, 0, 0, 7));
   endtask

   task automatic t_busy();
      logic [31:0] v;
      logic [63:0] p;
      reg_wr(0, ctlw(2, 0, 1, 0, 0));
      reg_wr(4, 32'h500);
      reg_wr(4, 32'h600);
      reg_rd(0, v); chk("R12 busy bit", 64'(v[9]), 64'd1);
      wait_idle();
      reg_rd(4, v); chk("R12 addr write ignored", 64'(v), 64'h500);
      p = pat(64'h500);
      reg_rd(8, v); chk("R12 data from first read", 64'(v), 64'(p[31:0]));
      reg_rd(0, v); chk("R12 busy clear", 64'(v[9]), 64'd0);
   endtask

   initial begin
      #(5.0 * 100000);
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_sizes();
      t_writes();
      t_carry();
      t_read_on_data();
      t_fault_and_clear();
      t_bad_size();
      t_busy();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule